// File: doc/BRIEF.md
# Interrupt Vector Code Encoder

This block turns the interrupt state of a message controller into one 7-bit code that software can use directly as an index into a jump table. Two kinds of source feed it. The first is a set of 32 per-queue status flags. The second is eight module-level events: bus error, wake-up, receive overflow, address error, bus bandwidth error, timestamp timer overflow, mode change and invalid message. Each source has its own enable. Only sources that are both pending and enabled take part in the code and in the combined request line.

The event flags are kept in a sticky register that the block owns. A one-cycle event pulse sets a flag, and software clears it by writing ones through a clear mask. The receive-overflow flag is the exception: software cannot clear it, and it clears only while the module is switched off. A small watcher compares the current operating mode with the previous cycle and raises the mode-change flag when the mode moves onto the requested one. The block also latches the number of the acceptance filter that took the last message. The flag register is presented in a fixed 16-bit layout for software to read.

Top module: `irq_vector_encoder`

## Requirements
- R1: When no event is enabled and pending, the code equals the number of the lowest-numbered queue whose flag and enable are both 1 (codes 0x00 to 0x1F).
- R2: After reset the code is 0x40, the request is 0, the flag word is 0 and the filter field is 0. The code is 0x40 whenever no enabled source is pending.
- R3: The enabled, pending events map to fixed codes. Enable bit i selects code 0x41+i, in this order: 0 bus error, 1 wake-up, 2 receive overflow, 3 address error, 4 bandwidth error, 5 timer overflow, 6 mode change, 7 invalid message. Any such event outranks every queue, and among events the lowest code wins. No code outside 0x00–0x1F and 0x40–0x48 is ever produced.
- R4: A source whose enable is 0 has no effect on the code or the request, but its flag still sets.
- R5: An event pulse sets its sticky flag on the next clock edge, at these positions in the flag word: 15 invalid, 14 wake-up, 13 bus error, 12 system error (address or bandwidth error), 11 receive overflow, 3 mode change, 2 timer overflow.
- R6: Writing with clear-enable high clears each flag whose mask bit is 1. Bit 12 clears both system error sources. A set and a clear in the same cycle leave the flag set.
- R7: The receive-overflow flag ignores the software clear. It is cleared on any edge where module-on is 0.
- R8: The mode-change flag sets only in a cycle where the current mode differs from its value on the previous cycle and equals the requested mode.
- R9: The filter field loads the filter number on an edge where its valid is 1, and otherwise holds its value.
- R10: The request is the OR of all enabled, pending sources. Code and request are registered, so they follow a change in the queue or enable inputs one edge later, and follow an event pulse two edges later.
- R11: Flag word bit 0 is 1 while any enabled pending queue is marked transmit. Bit 1 is 1 while any enabled pending queue is marked receive. Both follow the inputs without a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| queue_flag_i | input | 32 | Per-queue interrupt status |
| queue_en_i | input | 32 | Per-queue interrupt enable |
| queue_is_tx_i | input | 32 | 1 marks a transmit queue, 0 marks a receive queue |
| bus_err_i | input | 1 | Bus error event pulse |
| wake_i | input | 1 | Wake-up event pulse |
| rx_ovf_i | input | 1 | Receive overflow event pulse |
| addr_err_i | input | 1 | Address error event pulse |
| bw_err_i | input | 1 | Bus bandwidth error event pulse |
| tmr_ovf_i | input | 1 | Timestamp timer overflow pulse |
| invalid_i | input | 1 | Invalid message event pulse |
| cur_mode_i | input | 3 | Current operating mode |
| req_mode_i | input | 3 | Requested operating mode |
| module_on_i | input | 1 | Module switched on |
| evt_en_i | input | 8 | Event enables, bit i for code 0x41+i |
| clr_we_i | input | 1 | Apply the clear mask this cycle |
| clr_mask_i | input | 16 | Write-one-to-clear mask in flag word layout |
| filt_hit_vld_i | input | 1 | Filter number valid |
| filt_hit_i | input | 5 | Number of the accepting filter |
| int_code_o | output | 7 | Interrupt code |
| filt_hit_o | output | 5 | Last accepting filter number |
| irq_o | output | 1 | Combined interrupt request |
| flags_o | output | 16 | Module flag word |

## Verification
The assertions assume that reset is released on a clock edge and that event inputs are clean single-cycle pulses. They also assume the current mode sits at the reset value of its watcher (0) when reset ends, so no spurious change is seen. The stimulus drives every input on the falling edge, keeps the mode at 0 through reset and raises each event for one cycle only. This keeps the checks on code legality, on agreement between request and code, on the protected overflow flag and on the held filter number inside those assumptions.

// File: rtl/icv_pkg.sv
package icv_pkg;
  localparam int CODE_W  = 7;
  localparam int FLAG_W  = 16;
  localparam int NEV     = 8;

  localparam logic [CODE_W-1:0] CODE_NONE     = 7'h40;
  localparam logic [CODE_W-1:0] CODE_EVT_BASE = 7'h41;

  // event index order equals code order above the base
  localparam int EV_BUS   = 0;
  localparam int EV_WAKE  = 1;
  localparam int EV_RXOVF = 2;
  localparam int EV_ADDR  = 3;
  localparam int EV_BW    = 4;
  localparam int EV_TMR   = 5;
  localparam int EV_MODE  = 6;
  localparam int EV_INV   = 7;

  // flag word bit positions read by software
  localparam int FB_TX    = 0;
  localparam int FB_RX    = 1;
  localparam int FB_TMR   = 2;
  localparam int FB_MODE  = 3;
  localparam int FB_RXOVF = 11;
  localparam int FB_SYS   = 12;
  localparam int FB_BUS   = 13;
  localparam int FB_WAKE  = 14;
  localparam int FB_INV   = 15;
endpackage

// File: rtl/icv_first_set.sv
module icv_first_set #(
  parameter int W  = 32,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // descending scan so the lowest set index is the last one written
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/icv_mode_watch.sv
module icv_mode_watch #(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] req_mode,
  output logic              hit
);
  logic [MODE_W-1:0] prev_q;

  always_comb begin
    hit = (cur_mode != prev_q) && (cur_mode == req_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_mode;
  end
endmodule

// File: rtl/icv_flag_bank.sv
module icv_flag_bank
  import icv_pkg::*;
#(
  parameter int N      = NEV,
  parameter int LOCKED = EV_RXOVF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         module_on,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    if (g == LOCKED) begin : g_lock
      // only a module-off cycle clears this bit
      always_comb begin
        flag_d[g] = module_on & (set_vec[g] | flag_q[g]);
      end
    end else begin : g_norm
      // set beats clear in the same cycle
      always_comb begin
        flag_d[g] = set_vec[g] | (flag_q[g] & ~clr_vec[g]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/irq_vector_encoder.sv
module irq_vector_encoder
  import icv_pkg::*;
#(
  parameter int NQ     = 32,
  parameter int FILT_W = 5,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NQ-1:0]     queue_flag_i,
  input  logic [NQ-1:0]     queue_en_i,
  input  logic [NQ-1:0]     queue_is_tx_i,
  input  logic              bus_err_i,
  input  logic              wake_i,
  input  logic              rx_ovf_i,
  input  logic              addr_err_i,
  input  logic              bw_err_i,
  input  logic              tmr_ovf_i,
  input  logic              invalid_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic [MODE_W-1:0] req_mode_i,
  input  logic              module_on_i,
  input  logic [NEV-1:0]    evt_en_i,
  input  logic              clr_we_i,
  input  logic [FLAG_W-1:0] clr_mask_i,
  input  logic              filt_hit_vld_i,
  input  logic [FILT_W-1:0] filt_hit_i,
  output logic [CODE_W-1:0] int_code_o,
  output logic [FILT_W-1:0] filt_hit_o,
  output logic              irq_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int QIW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int EIW = $clog2(NEV);

  logic              mode_hit;
  logic [NEV-1:0]    set_vec, clr_vec, ev_q, ev_pend;
  logic [NQ-1:0]     q_pend;
  logic              q_hit, e_hit;
  logic [QIW-1:0]    q_idx;
  logic [EIW-1:0]    e_idx;
  logic [CODE_W-1:0] code_d, code_q;
  logic              irq_d, irq_q;
  logic [FILT_W-1:0] filt_q;

  icv_mode_watch #(.MODE_W(MODE_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode_i),
    .req_mode(req_mode_i), .hit(mode_hit)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[EV_BUS]   = bus_err_i;
    set_vec[EV_WAKE]  = wake_i;
    set_vec[EV_RXOVF] = rx_ovf_i;
    set_vec[EV_ADDR]  = addr_err_i;
    set_vec[EV_BW]    = bw_err_i;
    set_vec[EV_TMR]   = tmr_ovf_i;
    set_vec[EV_MODE]  = mode_hit;
    set_vec[EV_INV]   = invalid_i;

    clr_vec           = '0;
    clr_vec[EV_BUS]   = clr_we_i & clr_mask_i[FB_BUS];
    clr_vec[EV_WAKE]  = clr_we_i & clr_mask_i[FB_WAKE];
    clr_vec[EV_ADDR]  = clr_we_i & clr_mask_i[FB_SYS];
    clr_vec[EV_BW]    = clr_we_i & clr_mask_i[FB_SYS];
    clr_vec[EV_TMR]   = clr_we_i & clr_mask_i[FB_TMR];
    clr_vec[EV_MODE]  = clr_we_i & clr_mask_i[FB_MODE];
    clr_vec[EV_INV]   = clr_we_i & clr_mask_i[FB_INV];
  end

  icv_flag_bank #(.N(NEV), .LOCKED(EV_RXOVF)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .module_on(module_on_i), .flag_q(ev_q)
  );

  always_comb begin
    q_pend  = queue_flag_i & queue_en_i;
    ev_pend = ev_q & evt_en_i;
  end

  icv_first_set #(.W(NQ), .IW(QIW)) u_qsel (
    .req(q_pend), .hit(q_hit), .idx(q_idx)
  );

  icv_first_set #(.W(NEV), .IW(EIW)) u_esel (
    .req(ev_pend), .hit(e_hit), .idx(e_idx)
  );

  always_comb begin
    if (e_hit)      code_d = CODE_EVT_BASE + CODE_W'(e_idx);
    else if (q_hit) code_d = CODE_W'(q_idx);
    else            code_d = CODE_NONE;
    irq_d = e_hit | q_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_NONE;
      irq_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              filt_q <= '0;
    else if (filt_hit_vld_i) filt_q <= filt_hit_i;
  end

  always_comb begin
    flags_o           = '0;
    flags_o[FB_TX]    = |(q_pend & queue_is_tx_i);
    flags_o[FB_RX]    = |(q_pend & ~queue_is_tx_i);
    flags_o[FB_TMR]   = ev_q[EV_TMR];
    flags_o[FB_MODE]  = ev_q[EV_MODE];
    flags_o[FB_RXOVF] = ev_q[EV_RXOVF];
    flags_o[FB_SYS]   = ev_q[EV_ADDR] | ev_q[EV_BW];
    flags_o[FB_BUS]   = ev_q[EV_BUS];
    flags_o[FB_WAKE]  = ev_q[EV_WAKE];
    flags_o[FB_INV]   = ev_q[EV_INV];
  end

  assign int_code_o = code_q;
  assign irq_o      = irq_q;
  assign filt_hit_o = filt_q;
endmodule

// File: rtl/icv_checker.sv
module icv_checker #(
  parameter int NQ     = 32,
  parameter int FILT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [6:0]        int_code_o,
  input logic              irq_o,
  input logic [15:0]       flags_o,
  input logic              module_on_i,
  input logic              filt_hit_vld_i,
  input logic [FILT_W-1:0] filt_hit_o,
  input logic [7:0]        evt_en_i,
  input logic [NQ-1:0]     queue_en_i
);
  assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_code_o <= 7'h1F) || (int_code_o >= 7'h40 && int_code_o <= 7'h48));

  assert_irq_matches_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (int_code_o != 7'h40));

  assert_ovf_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_o[11]) |-> !$past(module_on_i));

  assert_filter_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(filt_hit_vld_i) |-> $stable(filt_hit_o));

  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_en_i == '0 && queue_en_i == '0) |=> (!irq_o && int_code_o == 7'h40));
endmodule

bind irq_vector_encoder icv_checker #(.NQ(NQ), .FILT_W(FILT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_code_o(int_code_o), .irq_o(irq_o),
  .flags_o(flags_o), .module_on_i(module_on_i),
  .filt_hit_vld_i(filt_hit_vld_i), .filt_hit_o(filt_hit_o),
  .evt_en_i(evt_en_i), .queue_en_i(queue_en_i)
);

// File: tb/irq_vector_encoder_test.sv
`timescale 1ns/1ps
module irq_vector_encoder_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] qf, qe, qt;
  logic bus, wk, ovf, adr, bw, tmr, inv;
  logic [2:0] cm, rm;
  logic mon;
  logic [7:0] een;
  logic cwe;
  logic [15:0] cmask;
  logic fv;
  logic [4:0] fh;
  logic [6:0] code;
  logic [4:0] fo;
  logic irq;
  logic [15:0] flg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_encoder uut (
    .clk(clk), .rst_n(rst_n), .queue_flag_i(qf), .queue_en_i(qe),
    .queue_is_tx_i(qt), .bus_err_i(bus), .wake_i(wk), .rx_ovf_i(ovf),
    .addr_err_i(adr), .bw_err_i(bw), .tmr_ovf_i(tmr), .invalid_i(inv),
    .cur_mode_i(cm), .req_mode_i(rm), .module_on_i(mon), .evt_en_i(een),
    .clr_we_i(cwe), .clr_mask_i(cmask), .filt_hit_vld_i(fv),
    .filt_hit_i(fh), .int_code_o(code), .filt_hit_o(fo), .irq_o(irq),
    .flags_o(flg)
  );

  typedef struct packed {
    logic [31:0] q;
    logic [31:0] en;
    logic [6:0]  code;
    logic        irq;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 7'h40, 1'b0},
    '{32'h0000_0020, 32'hFFFF_FFFF, 7'h05, 1'b1},
    '{32'h8000_0001, 32'hFFFF_FFFF, 7'h00, 1'b1},
    '{32'h8000_0000, 32'hFFFF_FFFF, 7'h1F, 1'b1},
    '{32'h0000_0F00, 32'hFFFF_FEFF, 7'h09, 1'b1},
    '{32'hFFFF_FFFF, 32'h0000_0000, 7'h40, 1'b0},
    '{32'h0001_0010, 32'h0001_0000, 7'h10, 1'b1},
    '{32'h4000_0000, 32'hFFFF_FFFF, 7'h1E, 1'b1}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic clear(input logic [15:0] m);
    cwe = 1'b1; cmask = m; tick();
    cwe = 1'b0; cmask = '0; tick();
  endtask

  initial begin
    rst_n = 1'b0; qf = '0; qe = '0; qt = 32'hFFFF_0000;
    bus = 0; wk = 0; ovf = 0; adr = 0; bw = 0; tmr = 0; inv = 0;
    cm = '0; rm = '0; mon = 1'b1; een = '0; cwe = 0; cmask = '0;
    fv = 0; fh = '0;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R2 reset code", 32'(code), 32'h40);
    chk("R2 reset irq", 32'(irq), 0);
    chk("R2 reset flags", 32'(flg), 0);
    chk("R9 reset filter", 32'(fo), 0);

    // R1 R4 R10 R11 table
    for (int i = 0; i < NV; i++) begin
      qf = VECS[i].q; qe = VECS[i].en;
      tick(); tick();
      chk("R1 table code", 32'(code), 32'(VECS[i].code));
      chk("R10 table irq", 32'(irq), 32'(VECS[i].irq));
      chk("R11 tx flag", 32'(flg[0]), 32'(|(VECS[i].q & VECS[i].en & qt)));
      chk("R11 rx flag", 32'(flg[1]), 32'(|(VECS[i].q & VECS[i].en & ~qt)));
    end

    qf = 32'h0000_0008; qe = 32'hFFFF_FFFF; een = 8'h01;
    bus = 1; tick(); bus = 0; tick();
    chk("R3 bus error code", 32'(code), 32'h41);
    chk("R5 bus error flag", 32'(flg[13]), 1);

    tmr = 1; tick(); tmr = 0; tick();
    chk("R5 timer flag", 32'(flg[2]), 1);
    chk("R4 disabled timer code", 32'(code), 32'h41);

    clear(16'h2000);
    chk("R6 bus cleared", 32'(flg[13]), 0);
    chk("R6 code after clear", 32'(code), 32'h03);

    een = 8'h21; tick(); tick();
    chk("R4 timer enabled code", 32'(code), 32'h46);

    een = 8'hFF;
    adr = 1; bw = 1; tick(); adr = 0; bw = 0; tick();
    chk("R3 lowest event code", 32'(code), 32'h44);
    chk("R5 system flag", 32'(flg[12]), 1);
    clear(16'h1000);
    chk("R6 system cleared code", 32'(code), 32'h46);

    ovf = 1; tick(); ovf = 0; tick();
    chk("R3 overflow code", 32'(code), 32'h43);
    clear(16'hFFFF);
    chk("R7 overflow survives clear", 32'(flg[11]), 1);
    chk("R6 timer cleared", 32'(flg[2]), 0);
    mon = 1'b0; tick(); mon = 1'b1; tick();
    chk("R7 overflow off-cleared", 32'(flg[11]), 0);
    chk("R7 code after off", 32'(code), 32'h03);

    wk = 1; cwe = 1; cmask = 16'h4000; tick();
    wk = 0; cwe = 0; cmask = '0; tick();
    chk("R6 set wins flag", 32'(flg[14]), 1);
    chk("R3 wake code", 32'(code), 32'h42);
    clear(16'h4000);

    rm = 3'd4; cm = 3'd4; tick(); tick();
    chk("R8 mode flag", 32'(flg[3]), 1);
    chk("R3 mode code", 32'(code), 32'h47);
    clear(16'h0008);
    cm = 3'd2; tick(); tick();
    chk("R8 no match", 32'(flg[3]), 0);
    rm = 3'd2; tick(); tick();
    chk("R8 no change", 32'(flg[3]), 0);
    chk("R1 queue code back", 32'(code), 32'h03);

    inv = 1; tick(); inv = 0; tick();
    chk("R3 invalid code", 32'(code), 32'h48);
    chk("R5 invalid flag", 32'(flg[15]), 1);
    clear(16'h8000);

    een = 8'h00; qe = '0;
    tmr = 1; tick(); tmr = 0; tick();
    chk("R4 all masked irq", 32'(irq), 0);
    chk("R2 all masked code", 32'(code), 32'h40);
    een = 8'h20; tick(); tick();
    chk("R10 event only irq", 32'(irq), 1);
    chk("R3 event only code", 32'(code), 32'h46);

    fv = 1; fh = 5'h15; tick(); fv = 0; fh = 5'h0A; tick();
    chk("R9 filter loaded", 32'(fo), 32'h15);
    tick();
    chk("R9 filter held", 32'(fo), 32'h15);
    fv = 1; tick(); fv = 0; tick();
    chk("R9 filter reloaded", 32'(fo), 32'h0A);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule